// File: doc/BRIEF.md
# HDLC Receive Frame Length Checker

This block sits on the byte path between an HDLC receive deframer and the receive FIFO. It counts the bytes of each frame that actually reach the FIFO, including the status byte it appends when the frame ends. It compares that count against a programmable maximum, which software sets in units of 32 bytes. A frame that grows past the maximum is cut short. The block pulses an overflow interrupt, ends the frame with a status byte whose abort flag is set, and discards whatever the deframer still delivers for that frame.

The deframer presents one event per cycle: a frame start, a data byte, a normal end carrying the status byte, or an end caused by a line abort. A frame start latches the configuration for the whole frame. Every output is registered. A byte or status byte appears on the FIFO side exactly one cycle after the event that produced it.

Top module: `hdlc_rx_len_check`

## Requirements
- R1: After reset, `fifo_vld`, `fifo_sta`, `eom` and `ovf_irq` are all low.
- R2: While checking is inactive, or the limit has not been reached, each data byte appears on `fifo_dat` with `fifo_vld` high one cycle after it is presented. Bytes keep their order.
- R3: One cycle after a frame end, `fifo_vld`, `fifo_sta` and `eom` are high together and `fifo_dat` carries the status byte. After a normal end the status byte is passed on unchanged. After a line-abort end, bit 5 (the abort flag) is set.
- R4: The limit in bytes is (`lim_field` + 1) × 32, and the appended status byte counts as one byte. A frame of limit − 1 data bytes plus its status byte completes with no overflow.
- R5: A data byte that arrives after the frame already holds limit bytes is not forwarded. The next cycle carries a one-cycle `ovf_irq` pulse. The cycle after that carries a status byte of 0x20 (only bit 5 set) with `fifo_sta` and `eom`.
- R6: After an overflow on a data byte, the remaining data bytes of the frame and its real end produce no output. Exactly one status byte and one `eom` are emitted per frame.
- R7: If a frame has exactly limit data bytes, its status byte is the one that overflows. `ovf_irq` pulses, and the next cycle emits the deframer's status byte with bit 5 set, together with `eom`.
- R8: When `chk_en` is low or `hdlc_mode` is low at frame start, no length check is made: frames of any length pass unchanged and `ovf_irq` stays low.
- R9: `chk_en`, `hdlc_mode`, `ovf_ie` and `lim_field` are sampled only at frame start. Changing them during a frame has no effect until the next frame.
- R10: With `ovf_ie` low at frame start, an overflow still forces the abort status byte and `eom` at the same cycles, but `ovf_irq` stays low.
- R11: The byte count restarts at every frame start, so each frame is checked against the limit on its own.
- R12: With `lim_field` = 2047 (limit 65536), a frame of 65535 data bytes plus its status byte completes with no overflow; the count does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdlc_mode | input | 1 | Channel is in an HDLC mode (check allowed) |
| chk_en | input | 1 | Length check enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| lim_field | input | 11 | Limit code; limit = (code + 1) × 32 bytes |
| rx_sof | input | 1 | Frame start strobe from the deframer |
| rx_vld | input | 1 | Data byte strobe |
| rx_dat | input | 8 | Data byte |
| rx_end | input | 1 | Normal frame end strobe |
| rx_abt | input | 1 | Frame end caused by a line abort |
| rx_sta | input | 8 | Status byte for the ending frame |
| fifo_vld | output | 1 | Byte write to the receive FIFO |
| fifo_dat | output | 8 | Byte written to the FIFO |
| fifo_sta | output | 1 | Current FIFO byte is the status byte |
| eom | output | 1 | End-of-message pulse |
| ovf_irq | output | 1 | Length overflow interrupt pulse |

## Verification
The bench aims at the boundary around the limit. A frame one byte short of the limit must pass. A frame with exactly the limit in data bytes must overflow on its status byte, so an off-by-one in the comparison, or leaving the status byte out of the count, shows up as a missing or spurious interrupt. After an overflow, the bench feeds the rest of the frame and its real end. A design that keeps forwarding or that emits a second end-of-message produces unexpected scoreboard items. It also changes the configuration mid-frame, switches off the interrupt enable, and runs a frame at the 65536-byte maximum. A counter that is too narrow would see a limit of zero there and abort the frame immediately.

// File: rtl/hdlc_len_pkg.sv
package hdlc_len_pkg;
    localparam int BYTE_W    = 8;
    localparam int LIM_W     = 11;
    localparam int UNIT_LOG2 = 5;
    // one extra bit so the largest limit (2^(LIM_W+UNIT_LOG2)) fits unwrapped
    localparam int CNT_W     = LIM_W + UNIT_LOG2 + 1;
    localparam int ABT_BIT   = 5;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LIM_W-1:0]  lim_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic act;
        logic irq_en;
        cnt_t limit;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_OVF  = 2'd1,
        ST_DROP = 2'd2
    } st_e;

    typedef struct packed {
        logic  vld;
        logic  is_sta;
        logic  eom;
        byte_t dat;
    } obyte_t;

    function automatic cnt_t limit_bytes(input lim_t code);
        cnt_t units;
        units = cnt_t'(code) + cnt_t'(1);
        return units << UNIT_LOG2;
    endfunction

    function automatic byte_t mark_abort(input byte_t s);
        byte_t r;
        r = s;
        r[ABT_BIT] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/hdlc_len_cfg.sv
module hdlc_len_cfg
    import hdlc_len_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic hdlc_mode,
    input  logic chk_en,
    input  logic irq_en,
    input  lim_t lim_field,
    output cfg_t cfg
);
    // configuration is captured once per frame, at its start
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{act: 1'b0, irq_en: 1'b0, limit: limit_bytes(lim_t'(0))};
        end else if (sof) begin
            cfg <= '{act: chk_en & hdlc_mode, irq_en: irq_en, limit: limit_bytes(lim_field)};
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sof |=> $stable(cfg)); // R9
endmodule

// File: rtl/hdlc_len_cnt.sv
module hdlc_len_cnt
    import hdlc_len_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  cnt_t limit,
    output logic at_lim
);
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assign at_lim = (cnt_q == limit);

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt_q != '0)); // R12
    AST_INC_BELOW_LIM: assert property (@(posedge clk) disable iff (rst)
        inc |-> !at_lim); // R4
endmodule

// File: rtl/hdlc_len_fsm.sv
module hdlc_len_fsm
    import hdlc_len_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   act,
    input  logic   irq_en,
    input  logic   at_lim,
    input  logic   sof,
    input  logic   byte_vld,
    input  byte_t  byte_dat,
    input  logic   end_ok,
    input  logic   end_abt,
    input  byte_t  end_sta,
    output logic   inc,
    output obyte_t ob,
    output logic   ovf
);
    st_e    st_q, st_n;
    obyte_t ob_q, ob_n;
    logic   ovf_q, ovf_n;
    byte_t  hold_q, hold_n;
    logic   seen_q, seen_n;

    logic   ev_end;
    byte_t  sta_in;
    logic   hit;

    assign ev_end = end_ok | end_abt;
    assign sta_in = end_abt ? mark_abort(end_sta) : end_sta;
    // a byte (data or status) that would push the count past the limit
    assign hit    = act & at_lim & (byte_vld | ev_end);

    always_comb begin
        st_n   = st_q;
        ob_n   = '0;
        ovf_n  = 1'b0;
        hold_n = hold_q;
        seen_n = seen_q;
        inc    = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (hit) begin
                    st_n   = ST_OVF;
                    ovf_n  = irq_en;
                    hold_n = byte_vld ? byte_t'(0) : sta_in;
                    seen_n = ev_end & ~byte_vld;
                end else if (byte_vld) begin
                    ob_n = '{vld: 1'b1, is_sta: 1'b0, eom: 1'b0, dat: byte_dat};
                    inc  = act;
                end else if (ev_end) begin
                    ob_n = '{vld: 1'b1, is_sta: 1'b1, eom: 1'b1, dat: sta_in};
                    inc  = act;
                end
            end
            ST_OVF: begin
                ob_n = '{vld: 1'b1, is_sta: 1'b1, eom: 1'b1, dat: mark_abort(hold_q)};
                st_n = (seen_q || ev_end) ? ST_RUN : ST_DROP;
            end
            ST_DROP: begin
                if (ev_end || sof) begin
                    st_n = ST_RUN;
                end
            end
            default: st_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            ob_q   <= '0;
            ovf_q  <= 1'b0;
            hold_q <= '0;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            ob_q   <= ob_n;
            ovf_q  <= ovf_n;
            hold_q <= hold_n;
            seen_q <= seen_n;
        end
    end

    assign ob  = ob_q;
    assign ovf = ovf_q;

    AST_EOM_IS_STA: assert property (@(posedge clk) disable iff (rst)
        ob_q.eom |-> (ob_q.vld && ob_q.is_sta)); // R3
    AST_OVF_THEN_EOM: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> (ob_q.eom && ob_q.dat[ABT_BIT])); // R5
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> !ovf_q); // R5
    AST_OVF_NOT_WITH_EOM: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && ob_q.eom)); // R5
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DROP) |=> !ob_q.vld); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (irq_en && act)); // R10
endmodule

// File: rtl/hdlc_rx_len_check.sv
module hdlc_rx_len_check
    import hdlc_len_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdlc_mode,
    input  logic              chk_en,
    input  logic              ovf_ie,
    input  logic [LIM_W-1:0]  lim_field,
    input  logic              rx_sof,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_dat,
    input  logic              rx_end,
    input  logic              rx_abt,
    input  logic [BYTE_W-1:0] rx_sta,
    output logic              fifo_vld,
    output logic [BYTE_W-1:0] fifo_dat,
    output logic              fifo_sta,
    output logic              eom,
    output logic              ovf_irq
);
    cfg_t   cfg;
    logic   at_lim;
    logic   inc;
    obyte_t ob;

    hdlc_len_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .sof       (rx_sof),
        .hdlc_mode (hdlc_mode),
        .chk_en    (chk_en),
        .irq_en    (ovf_ie),
        .lim_field (lim_field),
        .cfg       (cfg)
    );

    hdlc_len_cnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (rx_sof),
        .inc    (inc),
        .limit  (cfg.limit),
        .at_lim (at_lim)
    );

    hdlc_len_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .act      (cfg.act),
        .irq_en   (cfg.irq_en),
        .at_lim   (at_lim),
        .sof      (rx_sof),
        .byte_vld (rx_vld),
        .byte_dat (rx_dat),
        .end_ok   (rx_end),
        .end_abt  (rx_abt),
        .end_sta  (rx_sta),
        .inc      (inc),
        .ob       (ob),
        .ovf      (ovf_irq)
    );

    assign fifo_vld = ob.vld;
    assign fifo_dat = ob.dat;
    assign fifo_sta = ob.is_sta;
    assign eom      = ob.eom;

    AST_CHECK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg.act |-> !ovf_irq); // R8
endmodule

// File: tb/hdlc_rx_len_check_test.sv
module hdlc_rx_len_check_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdlc_mode = 1'b1;
    logic        chk_en = 1'b1;
    logic        ovf_ie = 1'b1;
    logic [10:0] lim_field = '0;
    logic        rx_sof = 1'b0;
    logic        rx_vld = 1'b0;
    logic [7:0]  rx_dat = '0;
    logic        rx_end = 1'b0;
    logic        rx_abt = 1'b0;
    logic [7:0]  rx_sta = '0;
    logic        fifo_vld;
    logic [7:0]  fifo_dat;
    logic        fifo_sta;
    logic        eom;
    logic        ovf_irq;

    hdlc_rx_len_check uut (
        .clk(clk), .rst(rst), .hdlc_mode(hdlc_mode), .chk_en(chk_en),
        .ovf_ie(ovf_ie), .lim_field(lim_field), .rx_sof(rx_sof),
        .rx_vld(rx_vld), .rx_dat(rx_dat), .rx_end(rx_end), .rx_abt(rx_abt),
        .rx_sta(rx_sta), .fifo_vld(fifo_vld), .fifo_dat(fifo_dat),
        .fifo_sta(fifo_sta), .eom(eom), .ovf_irq(ovf_irq)
    );

    always #5 clk = ~clk;

    // kind: 0 data byte, 1 status byte with eom, 2 overflow pulse
    typedef struct {
        int         kind;
        logic [7:0] val;
        longint     ecyc;
        string      tag;
    } exp_t;

    exp_t   exp_q[$];
    longint cyc = 0;
    int     checks = 0;
    int     errors = 0;
    bit     done = 0;
    string  cur_tag = "R1";

    // reference model state, built from the requirements
    bit m_act = 0;
    bit m_ie = 0;
    int m_lim = 32;
    int m_cnt = 0;
    bit m_drop = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int kind, input logic [7:0] val, input longint ecyc);
        exp_t e;
        e.kind = kind; e.val = val; e.ecyc = ecyc; e.tag = cur_tag;
        exp_q.push_back(e);
    endtask

    task automatic clr_in();
        rx_sof = 1'b0; rx_vld = 1'b0; rx_end = 1'b0; rx_abt = 1'b0;
    endtask

    task automatic do_sof();
        @(negedge clk);
        clr_in();
        rx_sof = 1'b1;
        m_act = chk_en && hdlc_mode;
        m_ie = ovf_ie;
        m_lim = (int'(lim_field) + 1) * 32;
        m_cnt = 0;
        m_drop = 0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk);
        clr_in();
        rx_vld = 1'b1;
        rx_dat = b;
        if (!m_drop) begin
            if (m_act && m_cnt == m_lim) begin
                if (m_ie) push(2, 8'h00, cyc + 1);
                push(1, 8'h20, cyc + 2);
                m_drop = 1;
            end else begin
                push(0, b, cyc + 1);
                m_cnt++;
            end
        end
    endtask

    task automatic do_end(input logic [7:0] s, input bit abt);
        logic [7:0] s2;
        @(negedge clk);
        clr_in();
        if (abt) rx_abt = 1'b1; else rx_end = 1'b1;
        rx_sta = s;
        s2 = abt ? (s | 8'h20) : s;
        if (m_drop) begin
            m_drop = 0;
        end else if (m_act && m_cnt == m_lim) begin
            if (m_ie) push(2, 8'h00, cyc + 1);
            push(1, s2 | 8'h20, cyc + 2);
        end else begin
            push(1, s2, cyc + 1);
            m_cnt++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            clr_in();
        end
    endtask

    task automatic frame(input int nbytes, input logic [7:0] s, input bit abt);
        do_sof();
        for (int i = 0; i < nbytes; i++) do_byte(8'(i * 7 + 3));
        do_end(s, abt);
        idle(4);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (fifo_vld || eom || ovf_irq)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected output: vld=%0b dat=%h sta=%0b eom=%0b ovf=%0b at cycle %0d, expected none",
                         cur_tag, fifo_vld, fifo_dat, fifo_sta, eom, ovf_irq, cyc);
            end else begin
                exp_t e;
                bit ok;
                e = exp_q.pop_front();
                ok = (cyc == e.ecyc);
                case (e.kind)
                    0: ok = ok && fifo_vld && !fifo_sta && !eom && !ovf_irq && (fifo_dat == e.val);
                    1: ok = ok && fifo_vld && fifo_sta && eom && !ovf_irq && (fifo_dat == e.val);
                    default: ok = ok && ovf_irq && !fifo_vld && !eom;
                endcase
                if (!ok) begin
                    errors++;
                    $display("FAIL %s got vld=%0b dat=%h sta=%0b eom=%0b ovf=%0b cycle %0d, expected kind=%0d dat=%h cycle %0d",
                             e.tag, fifo_vld, fifo_dat, fifo_sta, eom, ovf_irq, cyc, e.kind, e.val, e.ecyc);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s, got no finish, expected finish", cur_tag);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 2; i++) begin
            checks++;
            if (fifo_vld || fifo_sta || eom || ovf_irq) begin
                errors++;
                $display("FAIL R1 reset outputs vld=%0b sta=%0b eom=%0b ovf=%0b, expected all 0",
                         fifo_vld, fifo_sta, eom, ovf_irq);
            end
            @(negedge clk);
        end
        rst = 1'b0;
        idle(3);

        cur_tag = "R2/R3 normal frame";
        lim_field = 11'd0;
        frame(10, 8'h81, 0);

        cur_tag = "R3 line abort";
        frame(5, 8'h01, 1);

        cur_tag = "R4 limit-1 data plus status";
        frame(31, 8'h82, 0);

        cur_tag = "R7 status byte overflows";
        frame(32, 8'h81, 0);

        cur_tag = "R5/R6 data overflow and drop";
        frame(40, 8'h84, 0);

        cur_tag = "R5/R6 overflow then line abort";
        frame(36, 8'h00, 1);

        cur_tag = "R4 code 1 accepted";
        lim_field = 11'd1;
        frame(63, 8'h90, 0);
        cur_tag = "R4 code 1 overflow";
        frame(70, 8'h90, 0);

        cur_tag = "R8 check disabled";
        lim_field = 11'd0;
        chk_en = 1'b0;
        frame(100, 8'h80, 0);
        cur_tag = "R8 not hdlc mode";
        chk_en = 1'b1;
        hdlc_mode = 1'b0;
        frame(100, 8'h80, 0);
        hdlc_mode = 1'b1;

        cur_tag = "R9 limit change mid-frame";
        lim_field = 11'd0;
        do_sof();
        for (int i = 0; i < 5; i++) do_byte(8'(i));
        lim_field = 11'd2047;
        for (int i = 0; i < 40; i++) do_byte(8'(i + 50));
        do_end(8'h81, 0);
        idle(4);
        cur_tag = "R9 enable change mid-frame";
        chk_en = 1'b0;
        lim_field = 11'd0;
        do_sof();
        for (int i = 0; i < 3; i++) do_byte(8'(i));
        chk_en = 1'b1;
        for (int i = 0; i < 40; i++) do_byte(8'(i + 9));
        do_end(8'h81, 0);
        idle(4);

        cur_tag = "R10 interrupt disabled";
        ovf_ie = 1'b0;
        frame(40, 8'h81, 0);
        frame(32, 8'h81, 0);
        ovf_ie = 1'b1;

        cur_tag = "R11 count restarts";
        frame(31, 8'h81, 0);
        frame(31, 8'h82, 0);
        frame(33, 8'h83, 0);

        cur_tag = "R12 maximum limit no wrap";
        lim_field = 11'd2047;
        frame(65535, 8'h81, 0);

        idle(6);
        cur_tag = "end of run";
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing outputs: got %0d pending, expected 0",
                     exp_q[0].tag, exp_q.size());
        end
        finish_run();
    end
endmodule